// File: doc/BRIEF.md
# Fuzzy Rule Weight Evaluator

This block turns a bank of antecedent activation levels into one rule strength per fuzzy rule. A stream of rule opcodes drives it. Each opcode picks up to four activation levels from the bank and may complement any of them. It then joins them with a single connective, where AND takes the minimum and OR takes the maximum. The result is a weight on the same 16-level truth scale as the inputs.

Several rule terms that feed the same consequent can be folded together. An opcode with its merge flag set takes the maximum of its own term and the weight emitted just before it, so the last opcode of such a chain carries the OR of the whole group. Each opcode yields exactly one weight, one clock later, tagged with its position in the rule sequence.

Top module: `fz_rule_weight`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `theta_valid`, `theta` and `rule_idx` are zero. The merge history is also cleared, so a merging opcode right after reset sees a previous weight of 0.
- R2: Opcode layout, with S = log2(NALPHA) (16 bits for S=4):
  - operand i selects alpha index `op_word[i*S +: S]`;
  - its complement flag is bit 4S+i;
  - its enable flag is bit 4S+4+i;
  - the connective is bit 4S+8 (0 = AND, 1 = OR);
  - the merge flag is bit 4S+9.
  - Alpha j sits at `alpha_flat[j*W +: W]`.
  - With connective AND, the term is the minimum of the enabled operands.
- R3: With connective OR, the term is the maximum of the enabled operands.
- R4: An operand whose complement flag is set contributes (2^W-1) minus its alpha (15 - alpha for W=4) instead of the alpha.
- R5: A disabled operand has no effect on the term. With no operand enabled, the term is 2^W-1 (15) for AND and 0 for OR.
- R6: With the merge flag clear, the emitted weight is the term. With it set, the emitted weight is the maximum of the term and the most recently emitted weight.
- R7: Timing of the output:
  - `theta_valid` is high for exactly one cycle after each clock edge at which `op_valid` is high, and low otherwise;
  - `theta` and `rule_idx` change only together with such a pulse and otherwise hold their value.
- R8: `rule_idx` numbers emitted weights 0, 1, 2, ... in acceptance order and returns to 0 after NRULES-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| alpha_flat | input | NALPHA*W | Activation level bank, alpha j at bits j*W +: W |
| op_valid | input | 1 | Opcode present this cycle |
| op_word | input | 4*log2(NALPHA)+10 | Rule opcode |
| theta_valid | output | 1 | One-cycle strobe for a new weight |
| theta | output | W | Rule weight |
| rule_idx | output | log2(NRULES) | Sequence number of the weight |

## Verification
The bench keeps the default 4-bit truth scale and 16-entry alpha bank. It uses NRULES=12 instead of 256, so the sequence counter wraps several times within a short run, and the wrap point is not a power of two. A cycle-accurate reference model checks every cycle under both directed and random input. The directed opcodes cover:
- all-disabled identities;
- complemented operands;
- merge chains that rise and fall;
- a merge issued straight after a mid-run reset.

The random phase mixes back-to-back opcodes with idle gaps.

// File: rtl/fz_pkg.sv
package fz_pkg;
  localparam int NOPS = 4;

  typedef enum logic {
    CONN_AND = 1'b0,
    CONN_OR  = 1'b1
  } fz_conn_e;
endpackage

// File: rtl/fz_op_decode.sv
module fz_op_decode
  import fz_pkg::*;
#(
  parameter int SEL_W = 4,
  localparam int OP_W = NOPS*SEL_W + 2*NOPS + 2
) (
  input  logic [OP_W-1:0]             op_word,
  output logic [NOPS-1:0][SEL_W-1:0]  sel,
  output logic [NOPS-1:0]             neg,
  output logic [NOPS-1:0]             en,
  output fz_conn_e                    conn,
  output logic                        merge
);
  localparam int NEG_LSB  = NOPS*SEL_W;
  localparam int EN_LSB   = NEG_LSB + NOPS;
  localparam int CONN_BIT = EN_LSB + NOPS;
  localparam int MRG_BIT  = CONN_BIT + 1;

  for (genvar i = 0; i < NOPS; i++) begin : g_sel
    assign sel[i] = op_word[i*SEL_W +: SEL_W];
  end

  assign neg   = op_word[NEG_LSB +: NOPS];
  assign en    = op_word[EN_LSB +: NOPS];
  assign conn  = fz_conn_e'(op_word[CONN_BIT]);
  assign merge = op_word[MRG_BIT];
endmodule

// File: rtl/fz_operand_lane.sv
module fz_operand_lane #(
  parameter int W      = 4,
  parameter int NALPHA = 16,
  parameter int SEL_W  = 4
) (
  input  logic [NALPHA*W-1:0] alpha_flat,
  input  logic [SEL_W-1:0]    sel,
  input  logic                neg,
  input  logic                en,
  input  logic                conn_or,
  output logic [W-1:0]        opnd
);
  function automatic logic [W-1:0] complement_level(input logic [W-1:0] a);
    return {W{1'b1}} - a;
  endfunction

  function automatic logic [W-1:0] identity_level(input logic use_max);
    return use_max ? {W{1'b0}} : {W{1'b1}};
  endfunction

  logic [W-1:0] picked;
  logic [W-1:0] shaped;

  always_comb begin
    picked = '0;
    for (int j = 0; j < NALPHA; j++) begin
      if (int'(sel) == j) picked = alpha_flat[j*W +: W];
    end
  end

  assign shaped = neg ? complement_level(picked) : picked;
  assign opnd   = en ? shaped : identity_level(conn_or);
endmodule

// File: rtl/fz_reduce.sv
module fz_reduce
  import fz_pkg::*;
#(
  parameter int W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    check_en,
  input  logic [NOPS-1:0][W-1:0]  opnds,
  input  logic                    conn_or,
  output logic [W-1:0]            term
);
  function automatic logic [W-1:0] lvl_min(input logic [W-1:0] a, input logic [W-1:0] b);
    return (a < b) ? a : b;
  endfunction

  function automatic logic [W-1:0] lvl_max(input logic [W-1:0] a, input logic [W-1:0] b);
    return (a > b) ? a : b;
  endfunction

  always_comb begin
    term = opnds[0];
    for (int i = 1; i < NOPS; i++) begin
      term = conn_or ? lvl_max(term, opnds[i]) : lvl_min(term, opnds[i]);
    end
  end

  for (genvar i = 0; i < NOPS; i++) begin : g_bound
    AST_MIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (check_en && !conn_or) |-> (term <= opnds[i])); // R2
    AST_MAX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (check_en && conn_or) |-> (term >= opnds[i])); // R3
  end
endmodule

// File: rtl/fz_theta_out.sv
module fz_theta_out #(
  parameter int W      = 4,
  parameter int NRULES = 256,
  parameter int IDX_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [W-1:0]     term,
  input  logic             merge,
  output logic             theta_valid,
  output logic [W-1:0]     theta,
  output logic [IDX_W-1:0] rule_idx
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NRULES - 1);

  function automatic logic [W-1:0] fold_or(input logic [W-1:0] a, input logic [W-1:0] b);
    return (a > b) ? a : b;
  endfunction

  logic [IDX_W-1:0] cnt_q;
  logic [W-1:0]     merged_val;
  logic             wrap_evt;

  assign merged_val = merge ? fold_or(term, theta) : term;
  assign wrap_evt   = accept && (cnt_q == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      theta_valid <= 1'b0;
      theta       <= '0;
      rule_idx    <= '0;
      cnt_q       <= '0;
    end else begin
      theta_valid <= accept;
      if (accept) begin
        theta    <= merged_val;
        rule_idx <= cnt_q;
        cnt_q    <= wrap_evt ? '0 : cnt_q + 1'b1;
      end
    end
  end

  AST_PULSE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> theta_valid); // R7
  AST_NO_SPURIOUS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> !theta_valid); // R7
  AST_THETA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> ($stable(theta) && $stable(rule_idx))); // R7
  AST_MERGE_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && merge) |=> (theta >= $past(theta))); // R6
  AST_MERGE_TERM: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (theta >= $past(term))); // R6
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (theta_valid && accept) |=>
      (int'(rule_idx) == ((int'($past(rule_idx)) + 1) % NRULES))); // R8
endmodule

// File: rtl/fz_rule_weight.sv
module fz_rule_weight
  import fz_pkg::*;
#(
  parameter int W      = 4,
  parameter int NALPHA = 16,
  parameter int NRULES = 256,
  localparam int SEL_W = (NALPHA > 1) ? $clog2(NALPHA) : 1,
  localparam int OP_W  = NOPS*SEL_W + 2*NOPS + 2,
  localparam int IDX_W = (NRULES > 1) ? $clog2(NRULES) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NALPHA*W-1:0] alpha_flat,
  input  logic                op_valid,
  input  logic [OP_W-1:0]     op_word,
  output logic                theta_valid,
  output logic [W-1:0]        theta,
  output logic [IDX_W-1:0]    rule_idx
);
  logic [NOPS-1:0][SEL_W-1:0] sel;
  logic [NOPS-1:0]            neg;
  logic [NOPS-1:0]            en;
  fz_conn_e                   conn;
  logic                       merge;
  logic                       conn_or;
  logic [NOPS-1:0][W-1:0]     opnds;
  logic [W-1:0]               term;

  fz_op_decode #(.SEL_W(SEL_W)) u_dec (
    .op_word (op_word),
    .sel     (sel),
    .neg     (neg),
    .en      (en),
    .conn    (conn),
    .merge   (merge)
  );

  assign conn_or = (conn == CONN_OR);

  for (genvar i = 0; i < NOPS; i++) begin : g_lane
    fz_operand_lane #(.W(W), .NALPHA(NALPHA), .SEL_W(SEL_W)) u_lane (
      .alpha_flat (alpha_flat),
      .sel        (sel[i]),
      .neg        (neg[i]),
      .en         (en[i]),
      .conn_or    (conn_or),
      .opnd       (opnds[i])
    );
  end

  fz_reduce #(.W(W)) u_red (
    .clk      (clk),
    .rst_n    (rst_n),
    .check_en (op_valid),
    .opnds    (opnds),
    .conn_or  (conn_or),
    .term     (term)
  );

  fz_theta_out #(.W(W), .NRULES(NRULES), .IDX_W(IDX_W)) u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept      (op_valid),
    .term        (term),
    .merge       (merge),
    .theta_valid (theta_valid),
    .theta       (theta),
    .rule_idx    (rule_idx)
  );

  AST_NONE_ENABLED_AND: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (en == '0) && !conn_or && !merge) |=> (theta == {W{1'b1}})); // R5
  AST_NONE_ENABLED_OR: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (en == '0) && conn_or && !merge) |=> (theta == '0)); // R5
endmodule

// File: tb/fz_rule_weight_test.sv
module fz_rule_weight_test;
  localparam int W = 4, NA = 16, NR = 12, SW = 4, OPW = 26, IW = 4;

  logic clk = 1'b0, rst_n = 1'b0, op_valid = 1'b0;
  logic [OPW-1:0] op_word = '0;
  logic [NA*W-1:0] alpha_flat;
  logic theta_valid;
  logic [W-1:0] theta;
  logic [IW-1:0] rule_idx;

  int alpha_v [NA];
  int compared = 0, mismatched = 0, cycles = 0;
  string cur_tag = "R1";
  int ev = 0, et = 0, ei = 0, cnt = 0;

  always #2 clk = ~clk;

  always_comb
    for (int j = 0; j < NA; j++) alpha_flat[j*W +: W] = W'(alpha_v[j]);

  fz_rule_weight #(.W(W), .NALPHA(NA), .NRULES(NR)) uut (
    .clk(clk), .rst_n(rst_n), .alpha_flat(alpha_flat), .op_valid(op_valid),
    .op_word(op_word), .theta_valid(theta_valid), .theta(theta), .rule_idx(rule_idx));

  // reference: behavioural, integer arithmetic on the requirement text
  function automatic int ref_term(logic [OPW-1:0] w);
    int r, v;
    bit is_or;
    is_or = w[24];
    r = is_or ? 0 : 15;
    for (int i = 0; i < 4; i++) begin
      if (w[20+i]) begin
        v = alpha_v[int'(w[i*4 +: 4])];
        if (w[16+i]) v = 15 - v;
        if (is_or) r = (v > r) ? v : r;
        else       r = (v < r) ? v : r;
      end
    end
    return r;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      ev = 0; et = 0; ei = 0; cnt = 0;
    end else if (op_valid) begin
      int t;
      t = ref_term(op_word);
      if (op_word[25]) et = (t > et) ? t : et;
      else et = t;
      ei = cnt;
      cnt = (cnt + 1) % NR;
      ev = 1;
    end else begin
      ev = 0;
    end
  end

  always @(negedge clk) begin
    string tg;
    tg = rst_n ? cur_tag : "R1";
    compared++;
    if (int'(theta_valid) != ev) begin
      mismatched++;
      $display("FAIL R7 %s theta_valid: actual %0d expected %0d", tg, theta_valid, ev);
    end
    compared++;
    if (int'(theta) != et) begin
      mismatched++;
      $display("FAIL %s theta: actual %0d expected %0d", tg, theta, et);
    end
    compared++;
    if (int'(rule_idx) != ei) begin
      mismatched++;
      $display("FAIL R8 %s rule_idx: actual %0d expected %0d", tg, rule_idx, ei);
    end
  end

  function automatic logic [OPW-1:0] mk(int s0, int s1, int s2, int s3,
                                        int negm, int enm, int c_or, int mrg);
    logic [OPW-1:0] w;
    w = '0;
    w[3:0] = 4'(s0); w[7:4] = 4'(s1); w[11:8] = 4'(s2); w[15:12] = 4'(s3);
    w[19:16] = 4'(negm); w[23:20] = 4'(enm); w[24] = c_or[0]; w[25] = mrg[0];
    return w;
  endfunction

  task automatic send(logic [OPW-1:0] w);
    @(negedge clk);
    op_valid = 1'b1;
    op_word = w;
  endtask

  task automatic idle(int n);
    @(negedge clk);
    op_valid = 1'b0;
    op_word = '0;
    for (int k = 1; k < n; k++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    op_valid = 1'b0;
    cur_tag = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    if (cycles > 100000) begin
      mismatched++;
      $display("FAIL R7 watchdog: actual %0d cycles expected completion", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    for (int j = 0; j < NA; j++) alpha_v[j] = j;
    alpha_v[0] = 3; alpha_v[1] = 9; alpha_v[2] = 7; alpha_v[3] = 12;
    do_reset();

    cur_tag = "R2";
    send(mk(0, 1, 2, 3, 0, 15, 0, 0));           // min -> 3
    send(mk(3, 2, 1, 0, 0, 15, 0, 0));
    idle(2);
    cur_tag = "R3";
    send(mk(0, 1, 2, 3, 0, 15, 1, 0));           // max -> 12
    send(mk(0, 0, 2, 2, 0, 15, 1, 0));           // max -> 7
    idle(1);
    cur_tag = "R4";
    send(mk(0, 1, 2, 3, 1, 15, 0, 0));           // 12,9,7,12 -> 7
    send(mk(3, 1, 2, 0, 1, 15, 1, 0));           // 3,9,7,3 -> 9
    send(mk(0, 1, 2, 3, 15, 15, 0, 0));          // 12,6,8,3 -> 3
    idle(1);
    cur_tag = "R5";
    send(mk(0, 1, 2, 3, 0, 0, 0, 0));            // 15
    send(mk(0, 1, 2, 3, 0, 0, 1, 0));            // 0
    send(mk(0, 1, 2, 3, 0, 2, 0, 0));            // only op1 -> 9
    send(mk(0, 1, 2, 3, 0, 4, 1, 0));            // only op2 -> 7
    idle(2);
    cur_tag = "R6";
    send(mk(2, 0, 0, 0, 0, 1, 0, 0));            // 7
    send(mk(0, 0, 0, 0, 0, 1, 0, 1));            // max(3,7) -> 7
    send(mk(3, 0, 0, 0, 0, 1, 0, 1));            // 12
    send(mk(1, 0, 0, 0, 0, 1, 0, 0));            // no merge -> 9
    idle(3);
    send(mk(0, 0, 0, 0, 0, 1, 0, 1));            // max(3,9) after gap
    do_reset();
    cur_tag = "R1 R6";
    send(mk(0, 0, 0, 0, 0, 1, 0, 1));            // previous is 0 -> 3
    idle(1);
    cur_tag = "R7";
    send(mk(3, 0, 0, 0, 0, 1, 0, 0));
    idle(5);
    cur_tag = "R8";
    for (int k = 0; k < 30; k++) begin
      send(mk(k % 16, (k + 3) % 16, 0, 0, k % 4, 3, k % 2, 0));
      if (k % 7 == 6) idle(2);
    end
    idle(2);

    cur_tag = "R2 R3 R4 R5 R6 R7 R8";
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if ($urandom % 8 == 0) alpha_v[$urandom % NA] = int'($urandom % 16);
      op_valid = ($urandom % 4) != 0;
      op_word = OPW'($urandom);
    end
    idle(3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule